// File: doc/BRIEF.md
# Network Interrupt Status Aggregator

This block gathers interrupt requests from network slots and their ports into two 16-bit status words with active-low bits, and drives one level-sensitive interrupt line to the processor. Events arrive on two independent channels: a raise channel that marks a slot/port as pending, and a drop channel that withdraws it. Each channel carries a slot number and a port number. A fixed distribution maps each slot to a word and to a base bit. The port number is added to that base bit to select the bit that changes.

The mapping is uneven. Slot 0 owns a byte-wide field at the bottom of word 0, and the upper part of word 0 is also reachable through higher port numbers on slot 0. Slots 1 to 4 each own a nibble of word 1. Software reads the two words through a small combinational read port at fixed register offsets. The interrupt line stays high while any bit of either word is low.

Top module: `net_irq_aggregator`

## Requirements
- R1: After reset both status words read 0xFFFF and `irq` is low.
- R2: A raise event clears bit (base + port) of the slot's word. The new value is visible on the read port and at `irq` in the cycle after the event.
- R3: A drop event sets bit (base + port) of the slot's word back to 1, with the same one-cycle timing.
- R4: Slot 0 uses word 0 with base 0. Slots 1, 2, 3 and 4 use word 1 with bases 0, 4, 8 and 12. Word 0 bit 0 carries the on-board Ethernet ports, and word 0 bits 8 and 9 carry the two accelerator slots, which are reached as slot 0 ports 8 and 9.
- R5: `irq` is high exactly when word 0 or word 1 holds a 0 bit, and low when both words are 0xFFFF.
- R6: A read at byte offset 0x20 returns word 0. A read at 0x22 returns word 1. Any other offset returns 0x0000. There is no write path to the status words.
- R7: If a raise and a drop select the same bit in the same cycle, the raise wins and the bit becomes 0.
- R8: An event with slot number 5 or higher, or with a computed bit index of 16 or higher, changes no state.
- R9: An event for one slot in word 1 changes no bit outside that slot's own bit. Neighbouring nibbles keep their values.
- R10: A raise and a drop that select different bits in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_vld | input | 1 | Raise-event strobe |
| raise_slot | input | 3 | Slot number of the raise event |
| raise_port | input | 4 | Port number of the raise event |
| drop_vld | input | 1 | Drop-event strobe |
| drop_slot | input | 3 | Slot number of the drop event |
| drop_port | input | 4 | Port number of the drop event |
| rd_addr | input | 8 | Register byte offset for reads |
| rd_data | output | 16 | Value of the status word at the selected offset |
| irq | output | 1 | Combined level interrupt, high while anything is pending |

## Verification
Directed patterns come first.
- Single raises walk every slot's field. Their read-back tells a wrong base or a wrong word from a correct mapping.
- Sweeps over all four nibbles of word 1 expose leakage between neighbouring slots.
- Paired raise and drop events, on the same bit and on different bits, separate the raise-wins rule from an ordering bug or a lost update.
- Out-of-range slot numbers and overflowing bit indices confirm that such events are dropped without a trace.

A long stretch of random traffic on both channels, with the read offset alternating, is then compared every cycle against a behavioural model of both words and of the interrupt line.

// File: rtl/net_irq_pkg.sv
package net_irq_pkg;

   // Word index assigned to a slot: slot 0 alone in word 0, all others in word 1.
   function automatic int slot_word(input int slot);
      return (slot == 0) ? 0 : 1;
   endfunction

   // First bit of a slot's field inside its word.
   function automatic int slot_base(input int slot, input int field_w);
      return (slot == 0) ? 0 : (slot - 1) * field_w;
   endfunction

endpackage

// File: rtl/nia_slot_decoder.sv
module nia_slot_decoder #(
   parameter int SLOT_W    = 3,
   parameter int PORT_W    = 4,
   parameter int WORD_W    = 16,
   parameter int FIELD_W   = 4,
   parameter int NUM_SLOTS = 5,
   parameter int NUM_WORDS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 vld,
   input  logic [SLOT_W-1:0]    slot,
   input  logic [PORT_W-1:0]    port,
   output logic [NUM_WORDS-1:0] word_hit,
   output logic [WORD_W-1:0]    bit_mask
);
   import net_irq_pkg::*;

   int idx;
   int wsel;

   always_comb begin
      word_hit = '0;
      bit_mask = '0;
      idx      = slot_base(int'(slot), FIELD_W) + int'(port);
      wsel     = slot_word(int'(slot));
      if (vld && (int'(slot) < NUM_SLOTS) && (idx < WORD_W) && (wsel < NUM_WORDS)) begin
         word_hit[wsel] = 1'b1;
         bit_mask[idx]  = 1'b1;
      end
   end

   // R4: one event touches at most one word and at most one bit
   assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(word_hit) && $onehot0(bit_mask));

   // R8: a slot number beyond the table reaches no word
   assert_bad_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && int'(slot) >= NUM_SLOTS) |-> (word_hit == '0));

endmodule

// File: rtl/nia_status_word.sv
module nia_status_word #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] low_mask,
   input  logic [WORD_W-1:0] high_mask,
   output logic [WORD_W-1:0] word_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '1;
      else        word_q <= (word_q | high_mask) & ~low_mask;
   end

   // R2: a raised bit is low one cycle later
   assert_raise_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (low_mask != '0) |=> ((word_q & $past(low_mask)) == '0));

   // R3: a dropped bit that is not raised at the same time is high one cycle later
   assert_drop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((high_mask & ~low_mask) != '0) |=>
         ((word_q & $past(high_mask & ~low_mask)) == $past(high_mask & ~low_mask)));

   // R9: without an event the word keeps its value
   assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((low_mask | high_mask) == '0) |=> $stable(word_q));

endmodule

// File: rtl/nia_irq_combine.sv
module nia_irq_combine #(
   parameter int WORD_W    = 16,
   parameter int NUM_WORDS = 2
) (
   input  logic [NUM_WORDS*WORD_W-1:0] words_flat,
   output logic                        irq
);
   logic [NUM_WORDS-1:0] pend;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_pend
      assign pend[w] = ~(&words_flat[w*WORD_W +: WORD_W]);
   end

   assign irq = |pend;

endmodule

// File: rtl/net_irq_aggregator.sv
module net_irq_aggregator #(
   parameter int SLOT_W    = 3,
   parameter int PORT_W    = 4,
   parameter int WORD_W    = 16,
   parameter int FIELD_W   = 4,
   parameter int NUM_SLOTS = 5,
   parameter int ADDR_W    = 8,
   parameter int BASE_OFF  = 32,
   parameter int RD_STRIDE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              raise_vld,
   input  logic [SLOT_W-1:0] raise_slot,
   input  logic [PORT_W-1:0] raise_port,
   input  logic              drop_vld,
   input  logic [SLOT_W-1:0] drop_slot,
   input  logic [PORT_W-1:0] drop_port,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic              irq
);
   localparam int NUM_WORDS = 2;
   localparam int FLAT_W    = NUM_WORDS * WORD_W;

   // elaboration-time parameter checks
   if ((NUM_SLOTS - 1) * FIELD_W > WORD_W) begin : g_bad_fields
      $error("slot fields do not fit in a status word");
   end
   if (NUM_SLOTS > (1 << SLOT_W)) begin : g_bad_slot_w
      $error("slot number width too small for NUM_SLOTS");
   end
   if (BASE_OFF + RD_STRIDE * NUM_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("register offsets exceed the address width");
   end

   logic [NUM_WORDS-1:0] raise_hit, drop_hit;
   logic [WORD_W-1:0]    raise_mask, drop_mask;
   logic [FLAT_W-1:0]    words_flat;

   nia_slot_decoder #(
      .SLOT_W(SLOT_W), .PORT_W(PORT_W), .WORD_W(WORD_W), .FIELD_W(FIELD_W),
      .NUM_SLOTS(NUM_SLOTS), .NUM_WORDS(NUM_WORDS)
   ) raise_dec_i (
      .clk(clk), .rst_n(rst_n), .vld(raise_vld), .slot(raise_slot), .port(raise_port),
      .word_hit(raise_hit), .bit_mask(raise_mask)
   );

   nia_slot_decoder #(
      .SLOT_W(SLOT_W), .PORT_W(PORT_W), .WORD_W(WORD_W), .FIELD_W(FIELD_W),
      .NUM_SLOTS(NUM_SLOTS), .NUM_WORDS(NUM_WORDS)
   ) drop_dec_i (
      .clk(clk), .rst_n(rst_n), .vld(drop_vld), .slot(drop_slot), .port(drop_port),
      .word_hit(drop_hit), .bit_mask(drop_mask)
   );

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] lo_m, hi_m;
      assign lo_m = raise_hit[w] ? raise_mask : '0;
      assign hi_m = drop_hit[w]  ? drop_mask  : '0;

      nia_status_word #(.WORD_W(WORD_W)) word_i (
         .clk(clk), .rst_n(rst_n), .low_mask(lo_m), .high_mask(hi_m),
         .word_q(words_flat[w*WORD_W +: WORD_W])
      );
   end

   nia_irq_combine #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) irq_i (
      .words_flat(words_flat), .irq(irq)
   );

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (rd_addr == ADDR_W'(BASE_OFF + RD_STRIDE * w))
            rd_data = words_flat[w*WORD_W +: WORD_W];
      end
   end

   // R5: with both words idle the line is low
   assert_idle_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (words_flat == '1) |-> !irq);

   // R8: an out-of-range raise alone leaves every word unchanged
   assert_ignore_bad_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_vld && int'(raise_slot) >= NUM_SLOTS && !drop_vld) |=> $stable(words_flat));

   // R7: a raise always leaves its word with a low bit, even with a drop in the same cycle
   assert_raise_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_hit != '0) |=> irq);

endmodule

// File: tb/net_irq_aggregator_tb.sv
module net_irq_aggregator_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       raise_vld = 1'b0, drop_vld = 1'b0;
   logic [2:0] raise_slot = '0, drop_slot = '0;
   logic [3:0] raise_port = '0, drop_port = '0;
   logic [7:0] rd_addr = 8'h20;
   logic [15:0] rd_data;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   string cur_req = "R1";
   logic [15:0] m_w0 = 16'hFFFF, m_w1 = 16'hFFFF;

   always #5 clk = ~clk;

   net_irq_aggregator dut_i (
      .clk(clk), .rst_n(rst_n),
      .raise_vld(raise_vld), .raise_slot(raise_slot), .raise_port(raise_port),
      .drop_vld(drop_vld), .drop_slot(drop_slot), .drop_port(drop_port),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_bad++;
         $display("FAIL watchdog: actual cycle %0d expected below 50000", cyc);
         finish_run();
      end
   end

   // behavioural model: apply one event to the words
   task automatic model_apply(input logic v, input int s, input int p, input logic lvl);
      int b;
      if (!v || s > 4) return;
      b = (s == 0) ? p : (s - 1) * 4 + p;
      if (b > 15) return;
      if (s == 0) m_w0[b] = lvl;
      else        m_w1[b] = lvl;
   endtask

   task automatic check_now();
      logic [15:0] exp_rd;
      logic        exp_irq;
      if (rd_addr == 8'h20)      exp_rd = m_w0;
      else if (rd_addr == 8'h22) exp_rd = m_w1;
      else                       exp_rd = 16'h0000;
      exp_irq = (m_w0 != 16'hFFFF) || (m_w1 != 16'hFFFF);
      n_chk++;
      if (rd_data !== exp_rd) begin
         n_bad++;
         $display("FAIL %s rd_data at 0x%h: actual %h expected %h", cur_req, rd_addr, rd_data, exp_rd);
      end
      n_chk++;
      if (irq !== exp_irq) begin
         n_bad++;
         $display("FAIL %s irq: actual %b expected %b", cur_req, irq, exp_irq);
      end
   endtask

   // one cycle: drive events, let the edge pass, update model, check at the falling edge
   task automatic step(input logic rv, input int rs, input int rp,
                       input logic dv, input int ds, input int dp, input logic [7:0] addr);
      raise_vld = rv; raise_slot = 3'(rs); raise_port = 4'(rp);
      drop_vld  = dv; drop_slot  = 3'(ds); drop_port  = 4'(dp);
      rd_addr   = addr;
      @(posedge clk);
      model_apply(dv, ds, dp, 1'b1);
      model_apply(rv, rs, rp, 1'b0);
      @(negedge clk);
      raise_vld = 1'b0; drop_vld = 1'b0;
      check_now();
   endtask

   task automatic peek(input logic [7:0] addr);
      rd_addr = addr;
      #1;
      check_now();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state on both words
      cur_req = "R1";
      peek(8'h20); peek(8'h22);

      // R2 / R4: slot 0 ethernet bit, accelerator bits 8 and 9
      cur_req = "R2";
      step(1, 0, 0, 0, 0, 0, 8'h20);
      cur_req = "R4";
      step(1, 0, 8, 0, 0, 0, 8'h20);
      step(1, 0, 9, 0, 0, 0, 8'h20);
      peek(8'h22);
      // R4: each slot in word 1 at its own nibble
      for (int s = 1; s <= 4; s++) step(1, s, 1, 0, 0, 0, 8'h22);
      // R3: withdraw everything
      cur_req = "R3";
      step(0, 0, 0, 1, 0, 0, 8'h20);
      step(0, 0, 0, 1, 0, 8, 8'h20);
      step(0, 0, 0, 1, 0, 9, 8'h20);
      for (int s = 1; s <= 4; s++) step(0, 0, 0, 1, s, 1, 8'h22);
      cur_req = "R5";
      peek(8'h20);

      // R9: sweep all ports of each shared-word slot, others stay put
      cur_req = "R9";
      for (int s = 1; s <= 4; s++) begin
         for (int p = 0; p < 4; p++) step(1, s, p, 0, 0, 0, 8'h22);
         for (int p = 0; p < 4; p++) step(0, 0, 0, 1, s, p, 8'h22);
      end

      // R7: same bit raise and drop together
      cur_req = "R7";
      step(1, 3, 2, 1, 3, 2, 8'h22);
      step(1, 0, 5, 1, 0, 5, 8'h20);

      // R10: different bits in the same cycle
      cur_req = "R10";
      step(1, 2, 0, 1, 3, 2, 8'h22);
      step(1, 4, 3, 1, 0, 5, 8'h20);
      peek(8'h22);

      // R8: out-of-range slot and bit index
      cur_req = "R8";
      step(1, 5, 0, 0, 0, 0, 8'h22);
      step(1, 7, 3, 0, 0, 0, 8'h20);
      step(0, 0, 0, 1, 6, 0, 8'h22);
      step(1, 4, 5, 0, 0, 0, 8'h22);
      step(1, 2, 15, 0, 0, 0, 8'h22);
      peek(8'h20);

      // R6: unmapped offsets read zero
      cur_req = "R6";
      peek(8'h24); peek(8'h21); peek(8'h00); peek(8'h20);

      // random traffic
      cur_req = "R2";
      for (int i = 0; i < 3000; i++) begin
         step($urandom_range(0, 1), $urandom_range(0, 6), $urandom_range(0, 15),
              $urandom_range(0, 1), $urandom_range(0, 6), $urandom_range(0, 15),
              (i % 3 == 2) ? 8'h26 : ((i % 2 == 0) ? 8'h20 : 8'h22));
      end

      // R1: reset again with pending state
      cur_req = "R1";
      step(1, 1, 1, 0, 0, 0, 8'h22);
      rst_n = 1'b0;
      @(posedge clk);
      m_w0 = 16'hFFFF; m_w1 = 16'hFFFF;
      @(negedge clk);
      rst_n = 1'b1;
      peek(8'h20); peek(8'h22);

      finish_run();
   end
endmodule